// File: doc/BRIEF.md
# Multi-channel instrument status reporting core

This block gathers the fault state of a programmable instrument into a compact status byte. Each of up to ten channels supplies a live vector of fault conditions, and the instrument as a whole supplies a nine-bit questionable-condition vector. The nine questionable bits carry these faults: over-temperature (bit 0), over-voltage (bit 1), over-current (bit 2), over-power (bit 3), reversed input voltage (bit 4), sync timeout (bit 5), sine current limit (bit 6), fan failure (bit 7) and remote inhibit (bit 8).

Each condition vector is registered once. Rising and falling edges are qualified by programmable masks and latched into sticky event registers. A read clears an event register. Each channel's enabled events roll up into one bit of a channel summary event register. Masked OR-reductions of the questionable and channel-summary events drive two status byte bits. A third status byte bit follows the not-empty flag of an external output message queue.

A plain register port gives access to the registers. Writes complete on a clock edge. Read data is combinational while the read strobe is high, and a read of an event register clears that register on the same edge.

Top module: `istat_top`

## Requirements
- R1: After reset, every condition and event register reads 0, every rising-edge mask reads all ones, every falling-edge mask and every enable register reads 0, and the status byte is 0.
- R2: A condition register reads the value its input had at the previous clock edge. Writes to a condition register have no effect.
- R3: A 0-to-1 change of a condition bit sets its event bit at the edge that registers the change, but only when the matching rising-edge mask bit is 1.
- R4: A 1-to-0 change of a condition bit sets its event bit at the edge that registers the change, but only when the matching falling-edge mask bit is 1.
- R5: An event bit stays set until its register is read, even after the condition returns to its old level.
- R6: A read of an event register returns its current value and clears the register on that clock edge. Writes to an event register have no effect.
- R7: A qualifying edge that arrives at the same clock edge as a read-clear leaves its event bit set after the clear.
- R8: Status byte bit 3 is the OR of (questionable event AND questionable enable).
- R9: At each clock edge, channel summary event bit c is set when (channel c event AND channel c enable) is nonzero before that edge. The bit is sticky and is cleared by reads, following the rules of R5 to R7.
- R10: Status byte bit 2 is the OR of (summary event AND summary enable).
- R11: Status byte bit 4 equals the output-queue not-empty input. All other status byte bits are 0. Reading the status byte clears nothing.
- R12: Address bits [7:4] select a unit: 0 to NUM_CH-1 for the channels, 14 for the summary and 15 for the questionable unit. Bits [3:0] select a register: 0 for condition, 1 for rising mask, 2 for falling mask, 3 for event, 4 for enable and 5 for the status byte (unit 14 only). Unmapped addresses read 0. Registers read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_cond_i | input | NUM_CH*CH_W | Live channel conditions, channel c in bits [c*CH_W +: CH_W] |
| ques_cond_i | input | Q_W | Live questionable conditions |
| oq_not_empty_i | input | 1 | Output message queue holds data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid while reg_rd_i is high |
| stb_o | output | 8 | Status byte |

## Verification
The assertions take for granted that reset is held low for at least one clock edge. They also assume that the strobes and condition inputs change only away from the active edge, so each edge sees a single settled value. The stimulus changes every input just after the falling edge and never asserts a read and a write in the same cycle. Random condition flips, mask writes and reads, including reads that land on the edge that registers a new transition, stay within those rules.

// File: rtl/istat_pkg.sv
package istat_pkg;
  localparam logic [3:0] UNIT_SUM  = 4'hE;
  localparam logic [3:0] UNIT_QUES = 4'hF;

  localparam logic [3:0] K_COND   = 4'd0;
  localparam logic [3:0] K_RISE   = 4'd1;
  localparam logic [3:0] K_FALL   = 4'd2;
  localparam logic [3:0] K_EVENT  = 4'd3;
  localparam logic [3:0] K_ENABLE = 4'd4;
  localparam logic [3:0] K_STB    = 4'd5;

  // status byte assembly: summary on 2, questionable on 3, queue on 4
  function automatic logic [7:0] make_stb(input logic csum, input logic ques,
                                          input logic mav);
    logic [7:0] s;
    s    = '0;
    s[2] = csum;
    s[3] = ques;
    s[4] = mav;
    return s;
  endfunction
endpackage

// File: rtl/istat_unit.sv
module istat_unit #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] wdata_i,
  input  logic         wr_rise_i,
  input  logic         wr_fall_i,
  input  logic         wr_en_i,
  input  logic         rd_ev_i,
  output logic [W-1:0] cond_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] ev_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] set_o,
  output logic         hit_o
);
  logic [W-1:0] cond_q, rise_q, fall_q, ev_q, en_q;

  function automatic logic [W-1:0] edge_hits(input logic [W-1:0] prev,
                                             input logic [W-1:0] cur,
                                             input logic [W-1:0] up,
                                             input logic [W-1:0] down);
    return (up & ~prev & cur) | (down & prev & ~cur);
  endfunction

  assign set_o = edge_hits(cond_q, cond_i, rise_q, fall_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= '0;
      rise_q <= '1;
      fall_q <= '0;
      ev_q   <= '0;
      en_q   <= '0;
    end else begin
      cond_q <= cond_i;
      if (wr_rise_i) rise_q <= wdata_i;
      if (wr_fall_i) fall_q <= wdata_i;
      if (wr_en_i)   en_q   <= wdata_i;
      ev_q <= (rd_ev_i ? '0 : ev_q) | set_o;
    end
  end

  assign cond_o = cond_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign ev_o   = ev_q;
  assign en_o   = en_q;
  assign hit_o  = |(ev_q & en_q);

  // R5: without a read, no set event bit drops
  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_ev_i |=> ((ev_q & $past(ev_q)) == $past(ev_q)));
  // R7: a bit set at the same edge as a clear survives
  p_keep_new_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_o != '0) |=> ((ev_q & $past(set_o)) == $past(set_o)));
  // R6: a read with no new edge empties the register
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ev_i && set_o == '0) |=> (ev_q == '0));
endmodule

// File: rtl/istat_csum.sv
module istat_csum #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] wdata_i,
  input  logic         wr_en_i,
  input  logic         rd_ev_i,
  output logic [N-1:0] ev_o,
  output logic [N-1:0] en_o,
  output logic         any_o
);
  logic [N-1:0] ev_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q <= '0;
      en_q <= '0;
    end else begin
      if (wr_en_i) en_q <= wdata_i;
      ev_q <= (rd_ev_i ? '0 : ev_q) | hit_i;
    end
  end

  assign ev_o  = ev_q;
  assign en_o  = en_q;
  assign any_o = |(ev_q & en_q);

  // R9: a channel with enabled events marks its summary bit next cycle
  p_sum_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0) |=> ((ev_q & $past(hit_i)) == $past(hit_i)));
  // R9: summary obeys the read-clear rule
  p_sum_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ev_i && hit_i == '0) |=> (ev_q == '0));
endmodule

// File: rtl/istat_top.sv
module istat_top #(
  parameter int NUM_CH = 10,
  parameter int CH_W   = 9,
  parameter int Q_W    = 9,
  localparam int W1     = (NUM_CH > CH_W) ? NUM_CH : CH_W,
  localparam int W2     = (W1 > Q_W) ? W1 : Q_W,
  localparam int DATA_W = (W2 > 8) ? W2 : 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_CH*CH_W-1:0] chan_cond_i,
  input  logic [Q_W-1:0]         ques_cond_i,
  input  logic                   oq_not_empty_i,
  input  logic                   reg_wr_i,
  input  logic                   reg_rd_i,
  input  logic [7:0]             reg_addr_i,
  input  logic [DATA_W-1:0]      reg_wdata_i,
  output logic [DATA_W-1:0]      reg_rdata_o,
  output logic [7:0]             stb_o
);
  import istat_pkg::*;

  logic [3:0] unit_sel, kind_sel;
  assign unit_sel = reg_addr_i[7:4];
  assign kind_sel = reg_addr_i[3:0];

  logic [CH_W-1:0] c_cond [NUM_CH];
  logic [CH_W-1:0] c_rise [NUM_CH];
  logic [CH_W-1:0] c_fall [NUM_CH];
  logic [CH_W-1:0] c_ev   [NUM_CH];
  logic [CH_W-1:0] c_en   [NUM_CH];
  logic [CH_W-1:0] c_set  [NUM_CH];
  logic [NUM_CH-1:0] c_hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic sel;
    assign sel = (unit_sel == 4'(c));
    istat_unit #(.W(CH_W)) i_unit (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cond_i    (chan_cond_i[c*CH_W +: CH_W]),
      .wdata_i   (reg_wdata_i[CH_W-1:0]),
      .wr_rise_i (reg_wr_i && sel && kind_sel == K_RISE),
      .wr_fall_i (reg_wr_i && sel && kind_sel == K_FALL),
      .wr_en_i   (reg_wr_i && sel && kind_sel == K_ENABLE),
      .rd_ev_i   (reg_rd_i && sel && kind_sel == K_EVENT),
      .cond_o    (c_cond[c]),
      .rise_o    (c_rise[c]),
      .fall_o    (c_fall[c]),
      .ev_o      (c_ev[c]),
      .en_o      (c_en[c]),
      .set_o     (c_set[c]),
      .hit_o     (c_hit[c])
    );
  end

  logic [Q_W-1:0] q_cond, q_rise, q_fall, q_ev, q_en, q_set;
  logic           q_hit;
  logic           q_sel;
  assign q_sel = (unit_sel == UNIT_QUES);

  istat_unit #(.W(Q_W)) i_ques (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cond_i    (ques_cond_i),
    .wdata_i   (reg_wdata_i[Q_W-1:0]),
    .wr_rise_i (reg_wr_i && q_sel && kind_sel == K_RISE),
    .wr_fall_i (reg_wr_i && q_sel && kind_sel == K_FALL),
    .wr_en_i   (reg_wr_i && q_sel && kind_sel == K_ENABLE),
    .rd_ev_i   (reg_rd_i && q_sel && kind_sel == K_EVENT),
    .cond_o    (q_cond),
    .rise_o    (q_rise),
    .fall_o    (q_fall),
    .ev_o      (q_ev),
    .en_o      (q_en),
    .set_o     (q_set),
    .hit_o     (q_hit)
  );

  logic [NUM_CH-1:0] s_ev, s_en;
  logic              s_any;
  logic              s_sel;
  assign s_sel = (unit_sel == UNIT_SUM);

  istat_csum #(.N(NUM_CH)) i_csum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (c_hit),
    .wdata_i (reg_wdata_i[NUM_CH-1:0]),
    .wr_en_i (reg_wr_i && s_sel && kind_sel == K_ENABLE),
    .rd_ev_i (reg_rd_i && s_sel && kind_sel == K_EVENT),
    .ev_o    (s_ev),
    .en_o    (s_en),
    .any_o   (s_any)
  );

  assign stb_o = make_stb(s_any, q_hit, oq_not_empty_i);

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      if (q_sel) begin
        case (kind_sel)
          K_COND:   reg_rdata_o = DATA_W'(q_cond);
          K_RISE:   reg_rdata_o = DATA_W'(q_rise);
          K_FALL:   reg_rdata_o = DATA_W'(q_fall);
          K_EVENT:  reg_rdata_o = DATA_W'(q_ev);
          K_ENABLE: reg_rdata_o = DATA_W'(q_en);
          default:  reg_rdata_o = '0;
        endcase
      end else if (s_sel) begin
        case (kind_sel)
          K_EVENT:  reg_rdata_o = DATA_W'(s_ev);
          K_ENABLE: reg_rdata_o = DATA_W'(s_en);
          K_STB:    reg_rdata_o = DATA_W'(stb_o);
          default:  reg_rdata_o = '0;
        endcase
      end else begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (unit_sel == 4'(c)) begin
            case (kind_sel)
              K_COND:   reg_rdata_o = DATA_W'(c_cond[c]);
              K_RISE:   reg_rdata_o = DATA_W'(c_rise[c]);
              K_FALL:   reg_rdata_o = DATA_W'(c_fall[c]);
              K_EVENT:  reg_rdata_o = DATA_W'(c_ev[c]);
              K_ENABLE: reg_rdata_o = DATA_W'(c_en[c]);
              default:  reg_rdata_o = '0;
            endcase
          end
        end
      end
    end
  end

  // R11: the status byte never reports the queue flag wrongly after a queue change
  p_mav_follow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oq_not_empty_i) |-> stb_o[4]);
  // R8: a new enabled questionable edge raises the summary bit next cycle
  p_ques_raise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((q_set & q_en) != '0 && !(reg_wr_i && q_sel && kind_sel == K_ENABLE)) |=> stb_o[3]);
endmodule

// File: tb/test_istat_top.sv
module test_istat_top;
  localparam int NCH = 10;
  localparam int CW  = 9;
  localparam int QW  = 9;
  localparam int DW  = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [NCH*CW-1:0] ch_cond;
  logic [QW-1:0]     q_cond;
  logic              oq;
  logic              wr, rd;
  logic [7:0]        addr;
  logic [DW-1:0]     wdata;
  wire  [DW-1:0]     rdata;
  wire  [7:0]        stb;

  istat_top i_istat_top (
    .clk_i(clk), .rst_ni(rst_n), .chan_cond_i(ch_cond), .ques_cond_i(q_cond),
    .oq_not_empty_i(oq), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .stb_o(stb)
  );

  logic [CW-1:0]  m_cond [NCH];
  logic [CW-1:0]  m_rise [NCH];
  logic [CW-1:0]  m_fall [NCH];
  logic [CW-1:0]  m_ev   [NCH];
  logic [CW-1:0]  m_en   [NCH];
  logic [QW-1:0]  mq_cond, mq_rise, mq_fall, mq_ev, mq_en;
  logic [NCH-1:0] ms_ev, ms_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [7:0] a(input int unit, input int kind);
    return {4'(unit), 4'(kind)};
  endfunction

  function automatic logic [CW-1:0] edge_of(input logic [CW-1:0] old_v,
                                           input logic [CW-1:0] new_v,
                                           input logic [CW-1:0] up,
                                           input logic [CW-1:0] down);
    logic [CW-1:0] r;
    for (int b = 0; b < CW; b++)
      r[b] = (old_v[b] != new_v[b]) && (new_v[b] ? up[b] : down[b]);
    return r;
  endfunction

  function automatic logic [7:0] exp_stb();
    logic [7:0] s = 8'h00;
    s[2] = (ms_ev & ms_en) != 0;
    s[3] = (mq_ev & mq_en) != 0;
    s[4] = oq;
    return s;
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [7:0] ad);
    int u = int'(ad[7:4]);
    int k = int'(ad[3:0]);
    if (u == 15) begin
      case (k)
        0: return DW'(mq_cond);
        1: return DW'(mq_rise);
        2: return DW'(mq_fall);
        3: return DW'(mq_ev);
        4: return DW'(mq_en);
        default: return '0;
      endcase
    end
    if (u == 14) begin
      case (k)
        3: return DW'(ms_ev);
        4: return DW'(ms_en);
        5: return DW'(exp_stb());
        default: return '0;
      endcase
    end
    if (u < NCH) begin
      case (k)
        0: return DW'(m_cond[u]);
        1: return DW'(m_rise[u]);
        2: return DW'(m_fall[u]);
        3: return DW'(m_ev[u]);
        4: return DW'(m_en[u]);
        default: return '0;
      endcase
    end
    return '0;
  endfunction

  function automatic string kind_tag(input logic [3:0] k);
    case (k)
      4'd0: return "R2";
      4'd3: return "R6";
      4'd5: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_cond[c] = '0; m_rise[c] = '1; m_fall[c] = '0; m_ev[c] = '0; m_en[c] = '0;
    end
    mq_cond = '0; mq_rise = '1; mq_fall = '0; mq_ev = '0; mq_en = '0;
    ms_ev = '0; ms_en = '0;
  endtask

  // inputs are already applied; check, advance the model across one edge
  task automatic step(input string tag);
    logic [CW-1:0]  n_ev [NCH];
    logic [QW-1:0]  nq_ev;
    logic [NCH-1:0] ns_ev;
    int u, k;
    #1;
    chk("R8,R10,R11 status byte", DW'(stb), DW'(exp_stb()));
    if (rd) chk(tag, rdata, exp_read(addr));
    u = int'(addr[7:4]);
    k = int'(addr[3:0]);
    for (int c = 0; c < NCH; c++) begin
      n_ev[c] = ((rd && u == c && k == 3) ? '0 : m_ev[c]) |
                edge_of(m_cond[c], ch_cond[c*CW +: CW], m_rise[c], m_fall[c]);
      ns_ev[c] = (m_ev[c] & m_en[c]) != 0;
    end
    ns_ev = ((rd && u == 14 && k == 3) ? '0 : ms_ev) | ns_ev;
    nq_ev = ((rd && u == 15 && k == 3) ? '0 : mq_ev) |
            edge_of(mq_cond, q_cond, mq_rise, mq_fall);
    @(posedge clk);
    for (int c = 0; c < NCH; c++) begin
      m_ev[c] = n_ev[c];
      m_cond[c] = ch_cond[c*CW +: CW];
      if (wr && u == c && k == 1) m_rise[c] = wdata[CW-1:0];
      if (wr && u == c && k == 2) m_fall[c] = wdata[CW-1:0];
      if (wr && u == c && k == 4) m_en[c] = wdata[CW-1:0];
    end
    mq_ev = nq_ev; ms_ev = ns_ev; mq_cond = q_cond;
    if (wr && u == 15 && k == 1) mq_rise = wdata[QW-1:0];
    if (wr && u == 15 && k == 2) mq_fall = wdata[QW-1:0];
    if (wr && u == 15 && k == 4) mq_en = wdata[QW-1:0];
    if (wr && u == 14 && k == 4) ms_en = wdata[NCH-1:0];
    @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] ad, input string tag);
    rd = 1'b1; addr = ad;
    step(tag);
    rd = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] ad, input logic [DW-1:0] d);
    wr = 1'b1; addr = ad; wdata = d;
    step("R12");
    wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step("R12");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; ch_cond = '0; q_cond = '0; oq = 1'b0;
    wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    do_read(a(15, 1), "R1");
    do_read(a(3, 2), "R1");
    do_read(a(9, 4), "R1");
    do_read(a(15, 3), "R1");
    do_read(a(14, 5), "R1");
    chk("R1 status byte zero", DW'(stb), '0);

    // R2: condition follows input, writes ignored
    q_cond = 9'h105; step("R2");
    do_read(a(15, 0), "R2");
    do_write(a(15, 0), 10'h000);
    do_read(a(15, 0), "R2");
    do_read(a(15, 3), "R6");          // clears events from the rise
    do_read(a(15, 3), "R6");          // must be empty now
    do_write(a(15, 3), 10'h3FF);
    do_read(a(15, 3), "R6");

    // R3: rising edge masked on bit 1
    q_cond = 9'h000; do_write(a(15, 1), 10'h1FD);
    do_read(a(15, 3), "R3");
    q_cond = 9'h003; step("R3");
    do_read(a(15, 3), "R3");          // expect bit 0 only

    // R4: falling edges
    do_write(a(15, 2), 10'h002);
    q_cond = 9'h000; step("R4");
    do_read(a(15, 3), "R4");          // expect bit 1 only

    // R5: sticky after condition returns
    q_cond = 9'h010; step("R5");
    q_cond = 9'h000; idle(3);
    do_read(a(15, 3), "R5");

    // R8: questionable summary bit
    do_write(a(15, 4), 10'h080);
    q_cond = 9'h080; step("R8");
    chk("R8 ques bit", DW'(stb[3]), 10'd1);

    // R7: edge at the same edge as the clear
    q_cond = 9'h0C0; do_read(a(15, 3), "R7");
    do_read(a(15, 3), "R7");          // bit 6 must remain

    // R9, R10: channel roll-up
    do_write(a(4, 4), 10'h004);
    do_write(a(14, 4), 10'h010);
    ch_cond[4*CW +: CW] = 9'h004; step("R9");
    step("R9");
    do_read(a(14, 3), "R9");
    chk("R10 csum bit", DW'(stb[2]), 10'd1);
    do_read(a(4, 3), "R9");
    do_read(a(14, 3), "R9");
    do_read(a(14, 3), "R9");
    chk("R10 csum cleared", DW'(stb[2]), 10'd0);

    // R11: queue flag and non-clearing status byte read
    oq = 1'b1; do_read(a(14, 5), "R11");
    do_read(a(14, 5), "R11");
    oq = 1'b0; do_read(a(14, 5), "R11");

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      int op, u, k;
      if ($urandom_range(3) == 0) q_cond[$urandom_range(QW-1)] ^= 1'b1;
      if ($urandom_range(2) == 0) ch_cond[$urandom_range(NCH*CW-1)] ^= 1'b1;
      if ($urandom_range(7) == 0) oq = ~oq;
      op = $urandom_range(3);
      u  = $urandom_range(NCH + 1);
      if (u == NCH) u = 14;
      else if (u == NCH + 1) u = 15;
      k  = $urandom_range(5);
      if (op == 0) begin
        do_read(a(u, k), kind_tag(4'(k)));
      end else if (op == 1) begin
        do_write(a(u, k), DW'($urandom));
      end else begin
        step("R12");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule